// File: doc/BRIEF.md
# Age-Ordered Speculative Line Buffer

This block is a small side buffer that sits beside a data cache and takes the lines fetched by loads that have not yet committed. Every line carries the age stamp of the load that brought it in. A lookup carries the stamp of the asking instruction. It sees a line only when that line's filler is the same age or older, so a line pulled in down a wrong path can never change what an older instruction observes. Once the filler commits, the line becomes visible to every lookup and waits to be handed to the main cache.

Ages are wraparound counters of `TW` bits. All ordering is measured relative to `oldest_ts`, which is the stamp of the oldest instruction still in flight. A misprediction removes every uncommitted line younger than the squash stamp in one clock edge. When every slot is taken, an older fill evicts the youngest uncommitted line that is younger than itself. If no such line exists, the fill is refused.

Committed lines drain through a two-state machine. In `ST_IDLE` the promote output is quiet. The transition `take` fires from either state when a committed line exists: the lowest-index committed line is latched into the promote registers, its slot is freed, and the machine enters or stays in `ST_PROMOTE`. In that state `promote_valid` is high. The transition `empty` returns the machine to `ST_IDLE` when no committed line remains.

Top module: `spec_line_buf`

## Requirements
- R1: After reset no slot is valid, `promote_valid` is 0, and every lookup misses.
- R2: A fill with `fill_valid`=1 and no squash in the same cycle is accepted (`fill_ok`=1) when a free slot exists. From the next cycle, a lookup of that address with an age equal to or younger than the filler returns `look_hit`=1 and the filled data. A lookup of an address not held returns `look_hit`=0.
- R3: A lookup whose age is older than the filler of an uncommitted line at that address returns `look_hit`=0.
- R4: `commit_valid` with `commit_ts` marks every valid line stamped with that age as committed at the clock edge. From the next cycle, a committed line hits for a lookup of any age.
- R5: Committed lines are promoted one per cycle, lowest slot first. A line committed at edge k appears on `promote_addr`/`promote_data` with `promote_valid`=1 after edge k+1, and its slot is free after that edge. `promote_valid` drops one cycle after the last committed line is taken.
- R6: `squash_valid` with `squash_ts` invalidates, at that single edge, every uncommitted line strictly younger than `squash_ts`. Lines of the same or older age, and committed lines, stay.
- R7: A fill presented in a cycle with `squash_valid`=1 is refused (`fill_ok`=0) and leaves no line behind.
- R8: With all slots valid, a fill evicts the uncommitted line with the youngest age that is strictly younger than the fill (`fill_ok`=1). The evicted address then misses, and the other lines still hit.
- R9: With all slots valid and no uncommitted line younger than the fill, the fill is refused (`fill_ok`=0) and the stored lines are unchanged.
- R10: Ages compare as `(ts - oldest_ts) mod 2^TW`, so a stamp that has wrapped past zero is younger than one just below the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oldest_ts | input | TW | Age stamp of the oldest in-flight instruction |
| fill_valid | input | 1 | Fill request |
| fill_ts | input | TW | Age of the filling instruction |
| fill_addr | input | AW | Line address of the fill |
| fill_data | input | DW | Line data of the fill |
| fill_ok | output | 1 | Fill accepted this cycle |
| look_valid | input | 1 | Lookup request |
| look_ts | input | TW | Age of the looking instruction |
| look_addr | input | AW | Lookup address |
| look_hit | output | 1 | A visible line matches |
| look_data | output | DW | Data of the matching line |
| commit_valid | input | 1 | An instruction commits |
| commit_ts | input | TW | Age of the committing instruction |
| squash_valid | input | 1 | Misprediction flush |
| squash_ts | input | TW | Age of the squash point |
| promote_valid | output | 1 | A committed line is offered to the main cache |
| promote_addr | output | AW | Address of the promoted line |
| promote_data | output | DW | Data of the promoted line |

## Verification
The assertions watch four things on every cycle: that no surviving uncommitted line is younger than a squash point one edge after the squash, that fills are refused during a squash, that `promote_valid` only rises after a committed line existed, and that a plain fill adds one valid slot while an eviction keeps the count. Some behaviour can only be shown through the bench's scenarios. These include which exact line is chosen as victim, the data returned under age-gated visibility, the order and timing of promotion, and comparisons across the wrap point.

// File: rtl/spec_buf_pkg.sv
package spec_buf_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PROMOTE = 1'b1
    } drain_state_e;
endpackage

// File: rtl/sb_entry.sv
module sb_entry #(
    parameter int TW = 6,
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] oldest_ts,
    input  logic          squash_valid,
    input  logic [TW-1:0] squash_ts,
    input  logic          commit_valid,
    input  logic [TW-1:0] commit_ts,
    input  logic          load_en,
    input  logic [TW-1:0] load_ts,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          release_en,
    input  logic [TW-1:0] look_ts,
    input  logic [AW-1:0] look_addr,
    output logic          valid_o,
    output logic          cmt_o,
    output logic [TW-1:0] rel_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          hit_o
);
    logic          valid_q, cmt_q;
    logic [TW-1:0] ts_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [TW-1:0] squash_rel, look_rel;
    logic          kill;

    always_comb begin
        rel_o      = ts_q - oldest_ts;
        squash_rel = squash_ts - oldest_ts;
        look_rel   = look_ts - oldest_ts;
        kill       = squash_valid && valid_q && !cmt_q && (rel_o > squash_rel);
        hit_o      = valid_q && (addr_q == look_addr) && (cmt_q || (rel_o <= look_rel));
        valid_o    = valid_q;
        cmt_o      = cmt_q;
        addr_o     = addr_q;
        data_o     = data_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            cmt_q   <= 1'b0;
            ts_q    <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (load_en) begin
            valid_q <= 1'b1;
            cmt_q   <= 1'b0;
            ts_q    <= load_ts;
            addr_q  <= load_addr;
            data_q  <= load_data;
        end else if (release_en) begin
            valid_q <= 1'b0;
            cmt_q   <= 1'b0;
        end else if (kill) begin
            valid_q <= 1'b0;
        end else if (commit_valid && valid_q && (ts_q == commit_ts)) begin
            cmt_q <= 1'b1;
        end
    end

    // R6: one edge after a squash no uncommitted line younger than it survives
    p_squash_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> !(valid_q && !cmt_q &&
            (TW'(ts_q - $past(oldest_ts)) > TW'($past(squash_ts) - $past(oldest_ts)))));
endmodule

// File: rtl/sb_alloc.sv
module sb_alloc #(
    parameter int N  = 4,
    parameter int TW = 6,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  valid_vec,
    input  logic [N-1:0]  cmt_vec,
    input  logic [TW-1:0] rel_arr [N],
    input  logic [TW-1:0] fill_rel,
    output logic          has_slot,
    output logic          use_victim,
    output logic [IW-1:0] slot_idx
);
    logic          free_found, vic_found;
    logic [IW-1:0] free_idx, vic_idx;
    logic [TW-1:0] vic_rel;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
        vic_found = 1'b0;
        vic_idx   = '0;
        vic_rel   = '0;
        for (int i = 0; i < N; i++) begin
            if (valid_vec[i] && !cmt_vec[i] && (rel_arr[i] > fill_rel) &&
                (!vic_found || (rel_arr[i] > vic_rel))) begin
                vic_found = 1'b1;
                vic_idx   = IW'(i);
                vic_rel   = rel_arr[i];
            end
        end
        has_slot   = free_found || vic_found;
        use_victim = !free_found && vic_found;
        slot_idx   = free_found ? free_idx : vic_idx;
    end
endmodule

// File: rtl/spec_line_buf.sv
module spec_line_buf
    import spec_buf_pkg::*;
#(
    parameter int N  = 4,
    parameter int TW = 6,
    parameter int AW = 8,
    parameter int DW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] oldest_ts,
    input  logic          fill_valid,
    input  logic [TW-1:0] fill_ts,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    output logic          fill_ok,
    input  logic          look_valid,
    input  logic [TW-1:0] look_ts,
    input  logic [AW-1:0] look_addr,
    output logic          look_hit,
    output logic [DW-1:0] look_data,
    input  logic          commit_valid,
    input  logic [TW-1:0] commit_ts,
    input  logic          squash_valid,
    input  logic [TW-1:0] squash_ts,
    output logic          promote_valid,
    output logic [AW-1:0] promote_addr,
    output logic [DW-1:0] promote_data
);
    logic [N-1:0]  valid_vec, cmt_vec, hit_vec, load_en, release_en;
    logic [TW-1:0] rel_arr  [N];
    logic [AW-1:0] addr_arr [N];
    logic [DW-1:0] data_arr [N];
    logic [TW-1:0] fill_rel;
    logic          has_slot, use_victim, cmt_any;
    logic [IW-1:0] slot_idx, take_idx;
    drain_state_e  state_q, state_d;
    logic [AW-1:0] pr_addr_q;
    logic [DW-1:0] pr_data_q;

    assign fill_rel = fill_ts - oldest_ts;

    sb_alloc #(.N(N), .TW(TW)) u_alloc (
        .valid_vec (valid_vec),
        .cmt_vec   (cmt_vec),
        .rel_arr   (rel_arr),
        .fill_rel  (fill_rel),
        .has_slot  (has_slot),
        .use_victim(use_victim),
        .slot_idx  (slot_idx)
    );

    assign fill_ok = fill_valid && !squash_valid && has_slot;

    always_comb begin
        cmt_any  = 1'b0;
        take_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cmt_vec[i]) begin
                cmt_any  = 1'b1;
                take_idx = IW'(i);
            end
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_ent
            assign load_en[g]    = fill_ok && (slot_idx == IW'(g));
            assign release_en[g] = cmt_any && (take_idx == IW'(g));
            sb_entry #(.TW(TW), .AW(AW), .DW(DW)) u_ent (
                .clk         (clk),
                .rst_n       (rst_n),
                .oldest_ts   (oldest_ts),
                .squash_valid(squash_valid),
                .squash_ts   (squash_ts),
                .commit_valid(commit_valid),
                .commit_ts   (commit_ts),
                .load_en     (load_en[g]),
                .load_ts     (fill_ts),
                .load_addr   (fill_addr),
                .load_data   (fill_data),
                .release_en  (release_en[g]),
                .look_ts     (look_ts),
                .look_addr   (look_addr),
                .valid_o     (valid_vec[g]),
                .cmt_o       (cmt_vec[g]),
                .rel_o       (rel_arr[g]),
                .addr_o      (addr_arr[g]),
                .data_o      (data_arr[g]),
                .hit_o       (hit_vec[g])
            );
        end
    endgenerate

    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (look_valid && hit_vec[i]) begin
                look_hit  = 1'b1;
                look_data = data_arr[i];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cmt_any)  state_d = ST_PROMOTE;
            ST_PROMOTE: if (!cmt_any) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pr_addr_q <= '0;
            pr_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (cmt_any) begin
                pr_addr_q <= addr_arr[take_idx];
                pr_data_q <= data_arr[take_idx];
            end
        end
    end

    always_comb begin
        promote_valid = (state_q == ST_PROMOTE);
        promote_addr  = pr_addr_q;
        promote_data  = pr_data_q;
    end

    // R5: the promote output only starts after a committed line was present
    p_promote_after_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(promote_valid) |-> $past(cmt_any));

    // R7: no fill is taken while a squash is in progress
    p_no_fill_on_squash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> !fill_ok);

    // R2: a fill into a free slot grows the valid count by one
    p_fill_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_ok && !use_victim && !cmt_any) |=>
            ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

    // R8: an eviction replaces a line, so the valid count holds
    p_evict_keeps_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_ok && use_victim && !cmt_any) |=>
            ($countones(valid_vec) == $past($countones(valid_vec))));
endmodule

// File: tb/tb_spec_line_buf.sv
module tb_spec_line_buf;
    localparam int TW = 6;
    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] oldest_ts = '0;
    logic          fill_valid = 1'b0;
    logic [TW-1:0] fill_ts = '0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic          fill_ok;
    logic          look_valid = 1'b0;
    logic [TW-1:0] look_ts = '0;
    logic [AW-1:0] look_addr = '0;
    logic          look_hit;
    logic [DW-1:0] look_data;
    logic          commit_valid = 1'b0;
    logic [TW-1:0] commit_ts = '0;
    logic          squash_valid = 1'b0;
    logic [TW-1:0] squash_ts = '0;
    logic          promote_valid;
    logic [AW-1:0] promote_addr;
    logic [DW-1:0] promote_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spec_line_buf #(.N(4), .TW(TW), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .oldest_ts(oldest_ts),
        .fill_valid(fill_valid), .fill_ts(fill_ts), .fill_addr(fill_addr),
        .fill_data(fill_data), .fill_ok(fill_ok),
        .look_valid(look_valid), .look_ts(look_ts), .look_addr(look_addr),
        .look_hit(look_hit), .look_data(look_data),
        .commit_valid(commit_valid), .commit_ts(commit_ts),
        .squash_valid(squash_valid), .squash_ts(squash_ts),
        .promote_valid(promote_valid), .promote_addr(promote_addr),
        .promote_data(promote_data)
    );

    typedef struct packed {
        logic [TW-1:0] ts;
        logic [AW-1:0] addr;
        logic          hit;
        logic [DW-1:0] data;
        logic          older; // 1: visibility refusal (R3), 0: plain hit/miss (R2)
    } lk_vec_t;

    localparam lk_vec_t LK_TAB [8] = '{
        '{ts: 6'd5, addr: 8'd10, hit: 1'b1, data: 8'hA1, older: 1'b0},
        '{ts: 6'd9, addr: 8'd10, hit: 1'b1, data: 8'hA1, older: 1'b0},
        '{ts: 6'd4, addr: 8'd10, hit: 1'b0, data: 8'h00, older: 1'b1},
        '{ts: 6'd8, addr: 8'd20, hit: 1'b1, data: 8'hB2, older: 1'b0},
        '{ts: 6'd7, addr: 8'd20, hit: 1'b0, data: 8'h00, older: 1'b1},
        '{ts: 6'd3, addr: 8'd30, hit: 1'b1, data: 8'hC3, older: 1'b0},
        '{ts: 6'd2, addr: 8'd30, hit: 1'b0, data: 8'h00, older: 1'b1},
        '{ts: 6'd9, addr: 8'd40, hit: 1'b0, data: 8'h00, older: 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_fill(input logic [TW-1:0] ts, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic exp_ok, input string req);
        fill_valid = 1'b1; fill_ts = ts; fill_addr = a; fill_data = d;
        #1;
        check({req, " fill_ok"}, 32'(fill_ok), 32'(exp_ok));
        tick();
        fill_valid = 1'b0;
    endtask

    task automatic do_look(input logic [TW-1:0] ts, input logic [AW-1:0] a,
                           input logic exp_hit, input logic [DW-1:0] exp_d, input string req);
        look_valid = 1'b1; look_ts = ts; look_addr = a;
        #1;
        check({req, " look_hit"}, 32'(look_hit), 32'(exp_hit));
        if (exp_hit) check({req, " look_data"}, 32'(look_data), 32'(exp_d));
        look_valid = 1'b0;
    endtask

    task automatic do_commit(input logic [TW-1:0] ts);
        commit_valid = 1'b1; commit_ts = ts;
        tick();
        commit_valid = 1'b0;
    endtask

    task automatic do_squash(input logic [TW-1:0] ts);
        squash_valid = 1'b1; squash_ts = ts;
        tick();
        squash_valid = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1: empty after reset
        check("R1 promote_valid", 32'(promote_valid), 32'd0);
        do_look(6'd9, 8'd10, 1'b0, 8'h00, "R1");

        // R2: fills into free slots
        do_fill(6'd5, 8'd10, 8'hA1, 1'b1, "R2");
        do_fill(6'd8, 8'd20, 8'hB2, 1'b1, "R2");
        do_fill(6'd3, 8'd30, 8'hC3, 1'b1, "R2");

        // R2 / R3: table of age-gated lookups
        for (int i = 0; i < 8; i++) begin
            do_look(LK_TAB[i].ts, LK_TAB[i].addr, LK_TAB[i].hit, LK_TAB[i].data,
                    LK_TAB[i].older ? "R3 table" : "R2 table");
        end

        // R4: commit makes the line visible to any age
        do_commit(6'd3);
        do_look(6'd0, 8'd30, 1'b1, 8'hC3, "R4");
        check("R5 no promote yet", 32'(promote_valid), 32'd0);
        tick();
        // R5: promoted one edge later, slot freed
        check("R5 promote_valid", 32'(promote_valid), 32'd1);
        check("R5 promote_addr", 32'(promote_addr), 32'd30);
        check("R5 promote_data", 32'(promote_data), 32'hC3);
        do_look(6'd9, 8'd30, 1'b0, 8'h00, "R5 freed");
        tick();
        check("R5 promote drop", 32'(promote_valid), 32'd0);

        // R6 / R7: squash with a concurrent fill
        do_fill(6'd12, 8'd50, 8'hD4, 1'b1, "R2");
        fill_valid = 1'b1; fill_ts = 6'd7; fill_addr = 8'd60; fill_data = 8'h99;
        squash_valid = 1'b1; squash_ts = 6'd6;
        #1;
        check("R7 fill_ok during squash", 32'(fill_ok), 32'd0);
        tick();
        fill_valid = 1'b0; squash_valid = 1'b0;
        do_look(6'd20, 8'd20, 1'b0, 8'h00, "R6 younger gone");
        do_look(6'd20, 8'd50, 1'b0, 8'h00, "R6 younger gone");
        do_look(6'd20, 8'd10, 1'b1, 8'hA1, "R6 older kept");
        do_look(6'd20, 8'd60, 1'b0, 8'h00, "R7 no line");

        // R8: fill up, then leapfrog the youngest
        do_fill(6'd10, 8'd61, 8'h61, 1'b1, "R2");
        do_fill(6'd11, 8'd62, 8'h62, 1'b1, "R2");
        do_fill(6'd12, 8'd63, 8'h63, 1'b1, "R2");
        do_fill(6'd9,  8'd64, 8'hE5, 1'b1, "R8");
        do_look(6'd20, 8'd63, 1'b0, 8'h00, "R8 victim gone");
        do_look(6'd20, 8'd64, 1'b1, 8'hE5, "R8 new line");
        do_look(6'd20, 8'd62, 1'b1, 8'h62, "R8 others kept");

        // R9: no younger uncommitted line, fill refused
        do_fill(6'd15, 8'd65, 8'h65, 1'b0, "R9");
        do_look(6'd20, 8'd65, 1'b0, 8'h00, "R9 not stored");
        do_look(6'd20, 8'd61, 1'b1, 8'h61, "R9 unchanged");
        do_look(6'd20, 8'd10, 1'b1, 8'hA1, "R9 unchanged");

        // drain: squash 9..11, commit 5
        do_squash(6'd5);
        do_look(6'd20, 8'd64, 1'b0, 8'h00, "R6 squash all younger");
        do_commit(6'd5);
        tick();
        check("R5 second promote addr", 32'(promote_addr), 32'd10);
        check("R5 second promote valid", 32'(promote_valid), 32'd1);
        tick();

        // R10: wraparound ordering
        oldest_ts = 6'd60;
        do_fill(6'd62, 8'd70, 8'hF6, 1'b1, "R10");
        do_fill(6'd2,  8'd71, 8'h77, 1'b1, "R10");
        do_look(6'd63, 8'd71, 1'b0, 8'h00, "R10 wrapped filler younger");
        do_look(6'd63, 8'd70, 1'b1, 8'hF6, "R10");
        do_look(6'd3,  8'd71, 1'b1, 8'h77, "R10 wrapped looker");
        do_squash(6'd63);
        do_look(6'd3, 8'd71, 1'b0, 8'h00, "R10 squash across wrap");
        do_look(6'd3, 8'd70, 1'b1, 8'hF6, "R10 squash across wrap");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule